// File: doc/BRIEF.md
# Owned Clock Gate with Turn-Off Hysteresis

This block gates one clock. The gate can be owned by software or by a hardware request line. A small register port carries two 32-bit words. The first is a write-access word that is locked and unlocked by a key. The second is the gate control word, and writes to it only take effect while access is unlocked. In software ownership the enable field drives the gate. In hardware ownership the gate follows an asynchronous request pin, which is first brought into the clock domain through a two-flop synchronizer.

The real gate state is shown on a status pin, and it also reads back as a read-only field of the gate word. Software polls it after a change. The status lags the request on purpose. A turn-on becomes visible after a two-cycle settle. A turn-off is held back by an optional hysteresis delay, either short or long. If the request comes back during that window, the gate stays on. A build-time option marks the gate as never disableable: its enable field still stores what software writes, but the clock keeps running. The output clock passes through a latch-based gate cell, so it only ever carries whole high phases.

Top module: `clk_gate_ctrl`

## Requirements
- R1: After reset, both words read zero, the gate is off, the status pin is low and the output clock stays low.
- R2: A write to byte address 0 whose bits 31:8 equal 0x00A5A5 and whose bits 7:1 are zero sets the access state to bit 0. A 1 unlocks and a 0 locks. The access state reads back in bit 0 of address 0.
- R3: A write to address 0 with any other value in bits 31:1 is ignored, and the access state keeps its value.
- R4: While access is locked, a write to the gate word at byte address 4 leaves that word and the gate unchanged.
- R5: The gate word has these fields: bit 0 enable, bit 1 owner (1 means software), bit 2 hysteresis on, bit 3 long delay select, bit 4 read-only status. Under software ownership the gate follows the enable bit.
- R6: Under hardware ownership the enable bit has no effect. The gate turns on 3 clock edges after the edge that first samples the request high: 2 edges of synchronizer, then the 2-cycle settle that overlaps the second of them.
- R7: When the request rises, the status goes high at the second clock edge after the edge on which the request became visible.
- R8: With hysteresis off, the status goes low at the first edge after the request falls.
- R9: With hysteresis on, turn-off takes 8 edges when bit 3 is clear and 32 edges when it is set. A request that returns within the window cancels the turn-off.
- R10: A gate built as never-disableable turns on after reset and stays on whatever is written. Its enable bit still reads back as written.
- R11: The output clock is high only during high phases of the input clock, and only while the gate is on. It is low for the whole low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the clock being gated |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W | Byte address: 0 is access, 4 is gate |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| hw_req | input | 1 | Asynchronous hardware gate request |
| gate_status | output | 1 | Actual gate state |
| clk_out | output | 1 | Gated clock |

## Verification
A stuck delay counter, or one that loads the wrong limit, shows up on gate_status as an edge that arrives one or more cycles early or late. The check points sit on the last cycle before each expected change and on the cycle of the change, so such an error is caught within a single edge. An access state that is corrupted shows up at once when the gate word or access word is read back after the next write. A bad gate cell shows clk_out high during a low phase, or missing during a high phase, within one clock period.

// File: rtl/cg_pkg.sv
package cg_pkg;
  localparam logic [23:0] ACCESS_KEY = 24'h00A5A5;

  // gate control word, bit 3 down to bit 0
  typedef struct packed {
    logic hyst_long;
    logic hyst_en;
    logic sw_own;
    logic sw_en;
  } gate_cfg_t;

  localparam int CFG_W      = $bits(gate_cfg_t);
  localparam int STATUS_BIT = CFG_W;
endpackage

// File: rtl/cg_wr_guard.sv
module cg_wr_guard
  import cg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_access,
  input  logic [31:0] wdata,
  output logic        unlocked
);
  logic key_ok;
  assign key_ok = (wdata[31:8] == ACCESS_KEY) && (wdata[7:1] == 7'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 unlocked <= 1'b0;
    else if (wr_access && key_ok) unlocked <= wdata[0];
  end
endmodule

// File: rtl/cg_sync.sv
module cg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cg_gate_fsm.sv
module cg_gate_fsm #(
  parameter int ON_DLY    = 2,
  parameter int SHORT_DLY = 8,
  parameter int LONG_DLY  = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic want,
  input  logic hyst_en,
  input  logic hyst_long,
  output logic gate_on
);
  localparam int MAX_A   = (ON_DLY > SHORT_DLY) ? ON_DLY : SHORT_DLY;
  localparam int MAX_DLY = (MAX_A > LONG_DLY) ? MAX_A : LONG_DLY;
  localparam int CNT_W   = (MAX_DLY > 2) ? $clog2(MAX_DLY) : 1;
  localparam logic [CNT_W-1:0] LIM_ON    = CNT_W'(ON_DLY - 1);
  localparam logic [CNT_W-1:0] LIM_SHORT = CNT_W'(SHORT_DLY - 1);
  localparam logic [CNT_W-1:0] LIM_LONG  = CNT_W'(LONG_DLY - 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  always_comb begin
    if (!gate_on)     lim = LIM_ON;
    else if (!hyst_en) lim = '0;
    else if (hyst_long) lim = LIM_LONG;
    else              lim = LIM_SHORT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_on <= 1'b0;
      cnt     <= '0;
    end else if (want == gate_on) begin
      cnt <= '0;
    end else if (cnt >= lim) begin
      gate_on <= want;
      cnt     <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/cg_icg.sv
module cg_icg (
  input  logic clk,
  input  logic en,
  output logic gclk
);
  logic en_lat;

  always_latch begin
    if (!clk) en_lat = en;
  end

  assign gclk = clk & en_lat;
endmodule

// File: rtl/clk_gate_ctrl.sv
module clk_gate_ctrl
  import cg_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int SHORT_DLY   = 8,
  parameter int LONG_DLY    = 32,
  parameter bit NO_DISABLE  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              hw_req,
  output logic              gate_status,
  output logic              clk_out
);
  localparam logic [ADDR_W-1:0] ADDR_ACCESS = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_GATE   = ADDR_W'(4);

  logic      unlocked;
  gate_cfg_t cfg_q;
  logic      hw_req_s;
  logic      want;
  logic      gate_on;
  logic      hit_access, hit_gate;

  assign hit_access = reg_wr && (reg_addr == ADDR_ACCESS);
  assign hit_gate   = reg_wr && (reg_addr == ADDR_GATE);

  cg_wr_guard u_guard (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_access(hit_access),
    .wdata    (reg_wdata),
    .unlocked (unlocked)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cfg_q <= '0;
    else if (hit_gate && unlocked) cfg_q <= gate_cfg_t'(reg_wdata[CFG_W-1:0]);
  end

  cg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (hw_req),
    .q    (hw_req_s)
  );

  generate
    if (NO_DISABLE) begin : g_always_on
      assign want = 1'b1;
    end else begin : g_owned
      assign want = cfg_q.sw_own ? cfg_q.sw_en : hw_req_s;
    end
  endgenerate

  cg_gate_fsm #(
    .ON_DLY   (SYNC_STAGES),
    .SHORT_DLY(SHORT_DLY),
    .LONG_DLY (LONG_DLY)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .want     (want),
    .hyst_en  (cfg_q.hyst_en),
    .hyst_long(cfg_q.hyst_long),
    .gate_on  (gate_on)
  );

  cg_icg u_icg (
    .clk (clk),
    .en  (gate_on),
    .gclk(clk_out)
  );

  assign gate_status = gate_on;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_ACCESS)    reg_rdata[0] = unlocked;
    else if (reg_addr == ADDR_GATE) reg_rdata[STATUS_BIT:0] = {gate_on, cfg_q};
  end
endmodule

// File: rtl/cg_chk.sv
module cg_chk
  import cg_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter bit NO_DISABLE = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              unlocked,
  input logic [CFG_W-1:0]  cfg,
  input logic              want,
  input logic              gate_on,
  input logic              clk_out
);
  logic good_key, acc_wr, gate_wr;
  assign good_key = (reg_wdata[31:8] == ACCESS_KEY) && (reg_wdata[7:1] == 7'd0);
  assign acc_wr   = reg_wr && (reg_addr == ADDR_W'(0));
  assign gate_wr  = reg_wr && (reg_addr == ADDR_W'(4));

  AST_UNLOCK_FOLLOWS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && good_key) |=> (unlocked == $past(reg_wdata[0])));               // R2
  AST_BADKEY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && !good_key) |=> $stable(unlocked));                              // R3
  AST_LOCKED_GATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_wr && !unlocked) |=> $stable(cfg));                                  // R4
  AST_ON_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_on) |-> $past(want));                                           // R7
  AST_FAST_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_on && !want && !cfg[2]) |=> !gate_on);                               // R8
  AST_OFF_NEEDS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate_on) |-> !$past(want));                                          // R9
  AST_NEVER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    NO_DISABLE |-> !$fell(gate_on));                                           // R10
  AST_GCLK_LOW_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_out);                                                                 // R11
endmodule

bind clk_gate_ctrl cg_chk #(.ADDR_W(ADDR_W), .NO_DISABLE(NO_DISABLE)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .reg_wdata(reg_wdata),
  .unlocked (unlocked),
  .cfg      (cfg_q),
  .want     (want),
  .gate_on  (gate_on),
  .clk_out  (clk_out)
);

// File: tb/tb_clk_gate_ctrl.sv
`timescale 1ns/100ps
module tb_clk_gate_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        wr_a = 1'b0, wr_b = 1'b0;
  logic [3:0]  addr_a = '0, addr_b = '0;
  logic [31:0] wd_a = '0, wd_b = '0;
  logic [31:0] rd_a, rd_b;
  logic        hw_req = 1'b0;
  logic        st_a, st_b, gclk_a, gclk_b;

  clk_gate_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(wr_a), .reg_addr(addr_a), .reg_wdata(wd_a),
    .reg_rdata(rd_a), .hw_req(hw_req), .gate_status(st_a), .clk_out(gclk_a));

  clk_gate_ctrl #(.NO_DISABLE(1'b1)) dut_nd (
    .clk(clk), .rst_n(rst_n), .reg_wr(wr_b), .reg_addr(addr_b), .reg_wdata(wd_b),
    .reg_rdata(rd_b), .hw_req(1'b0), .gate_status(st_b), .clk_out(gclk_b));

  localparam logic [31:0] UNLOCK = 32'h00A5A501;
  localparam logic [31:0] LOCK   = 32'h00A5A500;

  typedef struct { int cyc; logic exp; string tag; } item_t;
  item_t q[$];
  item_t mon_it;
  int cyc = 0;
  int compared = 0;
  int mismatched = 0;
  int w;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // scoreboard: expected status of the main gate at a given cycle
  task automatic push(input int c, input logic e, input string tag);
    item_t it;
    int pos = q.size();
    it.cyc = c; it.exp = e; it.tag = tag;
    for (int i = 0; i < q.size(); i++)
      if (q[i].cyc > c) begin pos = i; break; end
    q.insert(pos, it);
  endtask

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      mon_it = q.pop_front();
      compared++;
      if (mon_it.cyc != cyc || st_a !== mon_it.exp) begin
        mismatched++;
        $display("FAIL %s status actual=%b expected=%b at cycle %0d (sampled %0d)",
                 mon_it.tag, st_a, mon_it.exp, mon_it.cyc, cyc);
      end
    end
  end

  task automatic wr(input bit nd, input logic [3:0] a, input logic [31:0] d, output int edge_n);
    @(negedge clk);
    if (nd) begin wr_b = 1'b1; addr_b = a; wd_b = d; end
    else    begin wr_a = 1'b1; addr_a = a; wd_a = d; end
    edge_n = cyc + 1;
    @(negedge clk);
    wr_a = 1'b0; wr_b = 1'b0;
  endtask

  task automatic rd(input bit nd, input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    if (nd) addr_b = a; else addr_a = a;
    #0.5;
    chk(tag, nd ? rd_b : rd_a, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clk_phase(input bit nd, input logic on, input string tag);
    repeat (3) begin
      @(posedge clk); #1;
      chk(tag, {31'd0, nd ? gclk_b : gclk_a}, {31'd0, on});
      @(negedge clk); #1;
      chk(tag, {31'd0, nd ? gclk_b : gclk_a}, 32'd0);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    idle(3);
    chk("R1 status in reset", {31'd0, st_a}, 32'd0);
    rst_n = 1'b1;
    idle(2);
    rd(0, 4'h0, 32'h0, "R1 access word");
    rd(0, 4'h4, 32'h0, "R1 gate word");
    clk_phase(0, 1'b0, "R1 clk_out idle");

    // locked write to gate word is dropped
    wr(0, 4'h4, 32'h3, w);
    push(w + 5, 1'b0, "R4 locked gate write");
    rd(0, 4'h4, 32'h0, "R4 gate word unchanged");
    idle(6);

    // key handling
    wr(0, 4'h0, 32'h00A5A401, w);
    rd(0, 4'h0, 32'h0, "R3 wrong key ignored");
    wr(0, 4'h0, 32'h00A5A503, w);
    rd(0, 4'h0, 32'h0, "R3 nonzero low bits ignored");
    wr(0, 4'h0, UNLOCK, w);
    rd(0, 4'h0, 32'h1, "R2 unlock");
    wr(0, 4'h0, 32'h12A5A500, w);
    rd(0, 4'h0, 32'h1, "R3 wrong key keeps unlock");

    // software on: status after two edges
    wr(0, 4'h4, 32'h3, w);
    push(w + 1, 1'b0, "R7 before settle");
    push(w + 2, 1'b1, "R7 settled on");
    idle(4);
    rd(0, 4'h4, 32'h13, "R5 fields and status");
    clk_phase(0, 1'b1, "R11 clk_out running");

    // software off, no hysteresis
    wr(0, 4'h4, 32'h2, w);
    push(w, 1'b1, "R8 off pending");
    push(w + 1, 1'b0, "R8 off immediate");
    idle(3);
    clk_phase(0, 1'b0, "R11 clk_out stopped");

    // short hysteresis
    wr(0, 4'h4, 32'h3, w);
    idle(3);
    wr(0, 4'h4, 32'h7, w);
    wr(0, 4'h4, 32'h6, w);
    push(w + 7, 1'b1, "R9 short still on");
    push(w + 8, 1'b0, "R9 short off");
    idle(12);

    // long hysteresis
    wr(0, 4'h4, 32'hF, w);
    push(w + 1, 1'b0, "R7 before settle");
    push(w + 2, 1'b1, "R7 settled on");
    idle(4);
    wr(0, 4'h4, 32'hE, w);
    push(w + 31, 1'b1, "R9 long still on");
    push(w + 32, 1'b0, "R9 long off");
    idle(36);

    // request returns inside the window
    wr(0, 4'h4, 32'hF, w);
    idle(4);
    wr(0, 4'h4, 32'hE, w);
    idle(4);
    wr(0, 4'h4, 32'hF, w);
    push(w + 26, 1'b1, "R9 cancel past window");
    push(w + 40, 1'b1, "R9 cancel stays on");
    idle(44);

    // hardware ownership
    wr(0, 4'h4, 32'hE, w);
    push(w + 32, 1'b0, "R9 long off");
    idle(36);
    wr(0, 4'h4, 32'h1, w);
    push(w + 10, 1'b0, "R6 enable ignored");
    idle(12);
    @(negedge clk); hw_req = 1'b1; w = cyc + 1;
    push(w + 2, 1'b0, "R6 hw on pending");
    push(w + 3, 1'b1, "R6 hw on");
    idle(6);
    @(negedge clk); hw_req = 1'b0; w = cyc + 1;
    push(w + 1, 1'b1, "R6 hw off pending");
    push(w + 2, 1'b0, "R6 hw off");
    idle(4);

    // relock
    wr(0, 4'h0, LOCK, w);
    rd(0, 4'h0, 32'h0, "R2 lock");
    wr(0, 4'h4, 32'h3, w);
    rd(0, 4'h4, 32'h1, "R4 relocked gate write");
    push(w + 10, 1'b0, "R4 gate stays off");
    idle(12);

    // never-disableable instance
    chk("R10 on after reset", {31'd0, st_b}, 32'd1);
    wr(1, 4'h0, UNLOCK, w);
    wr(1, 4'h4, 32'h2, w);
    rd(1, 4'h4, 32'h12, "R10 enable reads zero, gate on");
    idle(40);
    chk("R10 still on", {31'd0, st_b}, 32'd1);
    clk_phase(1, 1'b1, "R10 clock keeps running");

    while (q.size() > 0) @(negedge clk);
    idle(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule